// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Selectable Frame Format

This block is a full-duplex asynchronous serial port. Software reaches it through a four-entry register window: a control word, a status word, a transmit holding byte and a receive holding byte. The transmitter turns the held byte into a frame on `txd`. The receiver rebuilds frames from `rxd` and leaves each byte in the holding register until software reads it.

A frame is one low start bit, followed by 7, 8 or 9 data bits sent least significant bit first. An optional parity bit comes next, then one high stop bit. The line rests high between frames. Frame length, parity enable and parity sense can all be changed at run time.

The bit rate comes from a divider on the system clock. A 16x oversampling tick lasts `BASE_DIV << sel` clocks, so a bit lasts 16 such ticks. The receiver reports a parity mismatch, a low stop bit and a lost frame as three separate sticky flags. Three level interrupt outputs are provided: one for transmit space, one for received data and one for errors.

Top module: `uart_xcvr`

## Requirements
- R1: After reset `txd` is high, the control word reads 0x00, and the status word reads 0x01 (transmit buffer empty, all other flags clear).
- R2: Writing address 2 clears status bit 0 (transmit buffer empty). No frame leaves while control bit 1 (transmit enable) is 0. Once enabled, the held byte moves into the shifter and status bit 0 returns to 1.
- R3: A transmitted frame is a start bit (0), the data bits LSB first, the parity bit when enabled, and one stop bit (1). Control bits [6:5] select the data length: 00 gives 7 bits, 01 gives 8 bits, 1x gives 9 bits. Control bit 7 is the ninth transmitted bit.
- R4: In 9-bit mode the received ninth bit appears in status bit 7. In 7-bit mode the received byte reads with bit 7 equal to 0.
- R5: Status bit 5 enables parity and status bit 6 selects even sense. With even sense the parity bit is the XOR of the data bits; with odd sense it is the inverse of that XOR. A received parity bit that mismatches sets status bit 4.
- R6: A completed frame sets status bit 1 (receive full). Reading address 3 returns the byte and clears status bit 1.
- R7: A stop bit sampled low sets status bit 2 (framing error), and the byte is still delivered.
- R8: A frame that completes while status bit 1 is set sets status bit 3 (overrun). That frame is discarded and the held byte is unchanged.
- R9: Writing 0 to status bit 4, 3 or 2 clears that flag. Writing 1 leaves it unchanged.
- R10: A low pulse on `rxd` shorter than half a bit is ignored, and the receiver then accepts the next valid frame.
- R11: Control bits [4:2] select the rate. One bit lasts 16*BASE_DIV*2^sel clocks.
- R12: `irq_tx` equals transmit enable AND buffer empty. `irq_rx` equals receive full. `irq_err` is the OR of the three error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register select: 0 control, 1 status, 2 transmit, 3 receive |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe (a read of address 3 clears receive full) |
| rd_data | output | 8 | Register read data for `addr` |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_tx | output | 1 | Transmit buffer available |
| irq_rx | output | 1 | Receive byte waiting |
| irq_err | output | 1 | Any error flag set |

## Verification
The hardest cases to reach from the ports are the receive errors, because a well-formed frame never produces them. The bench serialises its own frames onto `rxd`. It can flip the parity bit, force the stop bit low, or send a pulse only a quarter bit long, and each case is checked before the next frame is sent. Overrun is reached by sending two frames back to back with no read in between. The bench then confirms that the first byte survives. It also confirms that the flag obeys the write-zero-to-clear rule and ignores a write of one.

// File: rtl/uart_xcvr.sv
module uart_xcvr #(
  parameter int BASE_DIV = 2,
  parameter int DIVW     = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       rxd,
  output logic       txd,
  output logic       irq_tx,
  output logic       irq_rx,
  output logic       irq_err
);
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_t;

  logic            tx_b8, tx_en, par_en, par_even;
  logic [1:0]      mode;
  logic [2:0]      baud;
  logic [7:0]      tx_buf, rx_buf;
  logic            tx_empty, rx_full, rx_b8;
  logic            par_err, ovr_err, frm_err;
  logic [DIVW-1:0] div_cnt, div_lim;
  logic            tick;
  logic [3:0]      nbits, stop_idx;
  logic [8:0]      dmask;

  logic [11:0]     tx_sh, fr;
  logic [3:0]      tx_left, tx_tcnt, fr_len;
  logic            tx_busy, tx_load;

  rx_st_t          rx_st;
  logic            rx_s1, rx_s2, rx_pbit;
  logic [3:0]      rx_tcnt, rx_idx;
  logic [8:0]      rx_sh;
  logic            rx_done, rd_rx, full_after_rd, rx_bad_par;

  assign div_lim  = DIVW'(BASE_DIV) << baud;
  assign tick     = (div_cnt >= div_lim - DIVW'(1));
  assign nbits    = (mode == 2'b00) ? 4'd7 : (mode == 2'b01) ? 4'd8 : 4'd9;
  assign stop_idx = nbits + {3'b000, par_en};
  always_comb
    for (int i = 0; i < 9; i++) dmask[i] = (4'(i) < nbits);

  always_comb begin
    logic [8:0] d9;
    d9 = {tx_b8, tx_buf} & dmask;
    fr = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < 9; i++)
      if (4'(i) < nbits) fr[i+1] = d9[i];
    if (par_en) fr[nbits + 4'd1] = (^d9) ^ ~par_even;
    fr_len = nbits + 4'd2 + {3'b000, par_en};
  end

  assign tx_busy = (tx_left != 4'd0);
  assign tx_load = tx_en && !tx_empty && !tx_busy;
  assign txd     = tx_busy ? tx_sh[0] : 1'b1;

  assign rd_rx         = rd_en && (addr == 2'd3);
  assign full_after_rd = rx_full && !rd_rx;
  assign rx_done       = tick && (rx_st == RX_BITS) && (rx_tcnt == 4'd15) && (rx_idx == stop_idx);
  assign rx_bad_par    = par_en && (rx_pbit != ((^(rx_sh & dmask)) ^ ~par_even));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= tick ? '0 : div_cnt + DIVW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_sh <= '1; tx_left <= '0; tx_tcnt <= '0;
    end else if (tx_load) begin
      tx_sh <= fr; tx_left <= fr_len; tx_tcnt <= '0;
    end else if (tx_busy && tick) begin
      tx_tcnt <= tx_tcnt + 4'd1;
      if (tx_tcnt == 4'd15) begin
        tx_sh   <= {1'b1, tx_sh[11:1]};
        tx_left <= tx_left - 4'd1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_s1 <= 1'b1; rx_s2 <= 1'b1;
    end else begin
      rx_s1 <= rxd; rx_s2 <= rx_s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_st <= RX_IDLE; rx_tcnt <= '0; rx_idx <= '0; rx_sh <= '0; rx_pbit <= 1'b0;
    end else if (tick) begin
      case (rx_st)
        RX_IDLE:
          if (!rx_s2) begin rx_st <= RX_START; rx_tcnt <= '0; end
        RX_START:
          if (rx_tcnt == 4'd7) begin
            rx_tcnt <= '0; rx_idx <= '0;
            rx_st   <= rx_s2 ? RX_IDLE : RX_BITS;
          end else rx_tcnt <= rx_tcnt + 4'd1;
        default: begin
          rx_tcnt <= rx_tcnt + 4'd1;
          if (rx_tcnt == 4'd15) begin
            rx_idx <= rx_idx + 4'd1;
            for (int i = 0; i < 9; i++)
              if (rx_idx == 4'(i) && rx_idx < nbits) rx_sh[i] <= rx_s2;
            if (par_en && rx_idx == nbits) rx_pbit <= rx_s2;
            if (rx_idx == stop_idx) rx_st <= RX_IDLE;
          end
        end
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {tx_b8, mode, baud, tx_en, par_en, par_even} <= '0;
      tx_buf <= '0; tx_empty <= 1'b1;
      rx_buf <= '0; rx_b8 <= 1'b0; rx_full <= 1'b0;
      {par_err, ovr_err, frm_err} <= '0;
    end else begin
      if (tx_load) tx_empty <= 1'b1;
      if (wr_en && addr == 2'd0) {tx_b8, mode, baud, tx_en} <= wr_data[7:1];
      if (wr_en && addr == 2'd2) begin tx_buf <= wr_data; tx_empty <= 1'b0; end
      if (wr_en && addr == 2'd1) begin
        par_even <= wr_data[6];
        par_en   <= wr_data[5];
        par_err  <= par_err & wr_data[4];
        ovr_err  <= ovr_err & wr_data[3];
        frm_err  <= frm_err & wr_data[2];
      end
      if (rd_rx) rx_full <= 1'b0;
      if (rx_done) begin
        if (full_after_rd) ovr_err <= 1'b1;
        else begin
          rx_buf  <= (nbits == 4'd7) ? {1'b0, rx_sh[6:0]} : rx_sh[7:0];
          rx_b8   <= (nbits == 4'd9) & rx_sh[8];
          rx_full <= 1'b1;
          if (rx_bad_par) par_err <= 1'b1;
          if (!rx_s2)     frm_err <= 1'b1;
        end
      end
    end

  always_comb
    case (addr)
      2'd0:    rd_data = {tx_b8, mode, baud, tx_en, 1'b0};
      2'd1:    rd_data = {rx_b8, par_even, par_en, par_err, ovr_err, frm_err, rx_full, tx_empty};
      2'd2:    rd_data = 8'h00;
      default: rd_data = rx_buf;
    endcase

  assign irq_tx  = tx_en & tx_empty;
  assign irq_rx  = rx_full;
  assign irq_err = par_err | ovr_err | frm_err;
endmodule

// File: rtl/uart_xcvr_chk.sv
module uart_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] addr,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       rd_en,
  input logic       txd,
  input logic       tx_busy,
  input logic       tx_empty,
  input logic       rx_full,
  input logic       rx_done,
  input logic       ovr_err,
  input logic [7:0] rx_buf
);
  // R3
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  // R2
  tx_write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2) |=> !tx_empty);

  // R6
  rx_read_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3 && !rx_done) |=> !rx_full);

  // R8
  overrun_keeps_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full && !(rd_en && addr == 2'd3)) |=> (ovr_err && $stable(rx_buf)));

  // R9
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && !wr_data[3] && !rx_done) |=> !ovr_err);
endmodule

bind uart_xcvr uart_xcvr_chk u_chk (.*);

// File: tb/sim_uart_xcvr.sv
module sim_uart_xcvr;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, rxd = 1'b1;
  logic [7:0] wr_data = '0, rd_data;
  logic       txd, irq_tx, irq_rx, irq_err;
  int         vectors = 0, misses = 0, cyc = 0;

  uart_xcvr u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
                .rd_en(rd_en), .rd_data(rd_data), .rxd(rxd), .txd(txd),
                .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      misses = misses + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  function automatic logic [11:0] model_frame(input logic [8:0] d, input int nb,
                                               input bit pe, input bit ev, output int len);
    logic [11:0] f;
    bit p;
    f = '1; f[0] = 1'b0; p = 1'b0;
    for (int i = 0; i < nb; i++) begin f[i+1] = d[i]; p = p ^ d[i]; end
    if (pe) f[nb+1] = ev ? p : ~p;
    len = nb + 2 + (pe ? 1 : 0);
    return f;
  endfunction

  task automatic send(input logic [11:0] f, input int len, input int bitclk);
    for (int k = 0; k < len; k++) begin
      @(negedge clk); rxd = f[k];
      repeat (bitclk - 1) @(negedge clk);
    end
    @(negedge clk); rxd = 1'b1;
  endtask

  task automatic capture(input int len, input int bitclk, output logic [11:0] f);
    int w;
    f = '1; w = 0;
    @(negedge clk);
    while (txd && w < 4000) begin @(negedge clk); w++; end
    repeat (bitclk / 2) @(negedge clk);
    f[0] = txd;
    for (int k = 1; k < len; k++) begin
      repeat (bitclk) @(negedge clk);
      f[k] = txd;
    end
    repeat (bitclk) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    logic [11:0] ef, got;
    int len;
    bit low_seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 txd idle", int'(txd), 1);
    rd(2'd0, d); check("R1 control reset", d, 8'h00);
    rd(2'd1, d); check("R1 status reset", d, 8'h01);
    check("R12 irq_tx when disabled", int'(irq_tx), 0);

    wr(2'd0, 8'h20);
    wr(2'd2, 8'h3C);
    low_seen = 1'b0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (!txd) low_seen = 1'b1; end
    check("R2 no frame while disabled", int'(low_seen), 0);
    rd(2'd1, d); check("R2 buffer empty cleared by write", int'(d[0]), 0);

    ef = model_frame(9'h03C, 8, 0, 0, len);
    wr(2'd0, 8'h22);
    capture(len, 32, got);
    check("R3 8-bit frame", got, ef);
    rd(2'd1, d); check("R2 buffer empty after load", int'(d[0]), 1);
    check("R12 irq_tx enabled and empty", int'(irq_tx), 1);

    wr(2'd1, 8'h7C);
    wr(2'd0, 8'h02);
    ef = model_frame(9'h05B, 7, 1, 1, len);
    wr(2'd2, 8'h5B);
    capture(len, 32, got);
    check("R5 7-bit even parity frame", got, ef);

    wr(2'd1, 8'h3C);
    wr(2'd0, 8'hC2);
    ef = model_frame(9'h181, 9, 1, 0, len);
    wr(2'd2, 8'h81);
    capture(len, 32, got);
    check("R3 9-bit odd parity frame", got, ef);

    wr(2'd1, 8'h1C);
    wr(2'd0, 8'h26);
    ef = model_frame(9'h096, 8, 0, 0, len);
    wr(2'd2, 8'h96);
    capture(len, 64, got);
    check("R11 doubled bit period", got, ef);

    wr(2'd0, 8'h22);
    ef = model_frame(9'h0C3, 8, 0, 0, len);
    send(ef, len, 32);
    repeat (8) @(negedge clk);
    rd(2'd1, d); check("R6 receive full set", int'(d[1]), 1);
    check("R12 irq_rx", int'(irq_rx), 1);
    rd(2'd3, d); check("R6 received byte", d, 8'hC3);
    rd(2'd1, d); check("R6 receive full cleared by read", int'(d[1]), 0);

    ef = model_frame(9'h011, 8, 0, 0, len);
    send(ef, len, 32);
    ef = model_frame(9'h022, 8, 0, 0, len);
    send(ef, len, 32);
    repeat (8) @(negedge clk);
    rd(2'd1, d); check("R8 overrun flag", int'(d[3]), 1);
    check("R12 irq_err", int'(irq_err), 1);
    wr(2'd1, 8'h1C);
    rd(2'd1, d); check("R9 write one keeps flag", int'(d[3]), 1);
    rd(2'd3, d); check("R8 first byte kept", d, 8'h11);
    wr(2'd1, 8'h14);
    rd(2'd1, d); check("R9 write zero clears overrun", d & 8'h1E, 8'h00);

    ef = model_frame(9'h05A, 8, 0, 0, len);
    ef[len-1] = 1'b0;
    send(ef, len, 32);
    repeat (64) @(negedge clk);
    rd(2'd1, d); check("R7 framing flag", int'(d[2]), 1);
    rd(2'd3, d); check("R7 byte delivered", d, 8'h5A);
    wr(2'd1, 8'h18);
    rd(2'd1, d); check("R9 framing cleared", int'(d[2]), 0);

    wr(2'd1, 8'h7C);
    ef = model_frame(9'h00F, 8, 1, 1, len);
    send(ef, len, 32);
    repeat (8) @(negedge clk);
    rd(2'd1, d); check("R5 good parity no error", int'(d[4]), 0);
    rd(2'd3, d); check("R5 byte with parity", d, 8'h0F);
    ef[9] = ~ef[9];
    send(ef, len, 32);
    repeat (8) @(negedge clk);
    rd(2'd1, d); check("R5 parity mismatch flag", int'(d[4]), 1);
    rd(2'd3, d);
    wr(2'd1, 8'h6C);
    rd(2'd1, d); check("R9 parity cleared, sense kept", d, 8'h61);

    wr(2'd1, 8'h1C);
    wr(2'd0, 8'h42);
    ef = model_frame(9'h1A5, 9, 0, 0, len);
    send(ef, len, 32);
    repeat (8) @(negedge clk);
    rd(2'd1, d); check("R4 ninth bit in status", int'(d[7]), 1);
    rd(2'd3, d); check("R4 9-bit low byte", d, 8'hA5);

    wr(2'd0, 8'h02);
    ef = model_frame(9'h06B, 7, 0, 0, len);
    send(ef, len, 32);
    repeat (8) @(negedge clk);
    rd(2'd3, d); check("R4 7-bit byte top bit zero", d, 8'h6B);

    @(negedge clk); rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (96) @(negedge clk);
    rd(2'd1, d); check("R10 short pulse ignored", d & 8'h1E, 8'h00);
    wr(2'd0, 8'h22);
    ef = model_frame(9'h099, 8, 0, 0, len);
    send(ef, len, 32);
    repeat (8) @(negedge clk);
    rd(2'd3, d); check("R10 next frame accepted", d, 8'h99);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule